// File: doc/BRIEF.md
# Interrupt Flag and Wake Controller

This block collects interrupt events for a small 8-bit processor core and turns them into two outputs: an interrupt request that makes the core jump to its vector, and a wake line that ends a low-power sleep state. It watches three sources. The first is an external pin whose active edge is chosen by software. The second is a one-cycle overflow pulse from an 8-bit timer. The third is a change detector on the upper four bits of an input port.

Each source has a sticky flag and its own enable bit. All of them sit in a control register that is reached through a small read/write register port. The edge choice for the external pin lives in a second register. Reading the port register returns the synchronized pin values. The same read also re-arms the change detector. Wake depends only on whether some source has both its flag and its enable set. The interrupt request additionally needs the global enable, which the block clears itself when the core takes the vector.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, the option register (address 1) reads 0x40 (rising edge selected), and irq_req and wake are low.
- R2: Register map for reads and writes. At address 0 (control), bit 7 is the global enable, bit 5 the timer enable, bit 4 the pin enable, bit 3 the port-change enable, bit 2 the timer flag, bit 1 the pin flag and bit 0 the port-change flag; bit 6 always reads 0. At address 1 only bit 6 (edge select) is stored, and all other bits read 0. Address 2 returns the synchronized port pins. Address 3 reads 0 and ignores writes.
- R3: With edge select at 1, a 0-to-1 change on ext_pin sets control bit 1 within four clock cycles. The pin passes through a two-stage synchronizer first.
- R4: With edge select at 0, a 1-to-0 change on ext_pin sets control bit 1. The opposite edge leaves the flag clear under either setting.
- R5: A one-cycle tmr_ovf pulse sets control bit 2 on the next clock edge.
- R6: When the synchronized port bits 7..4 differ from a stored snapshot, control bit 0 is set. Reading address 2 loads the snapshot. Changes on port bits 3..0 have no effect.
- R7: Flags are never cleared by hardware. A write of 0 to a flag bit clears it, and a write of 1 sets it.
- R8: If hardware sets a flag in the same cycle that software writes 0 to it, the flag ends up set.
- R9: wake is high whenever some source has both its flag and its enable set, whatever the global enable holds.
- R10: irq_req is high exactly when wake is high and the global enable (control bit 7) is set.
- R11: A vec_ack pulse clears the global enable. This overrides a control write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (re-arms port snapshot at address 2) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| tmr_ovf | input | 1 | One-cycle timer rollover pulse |
| port_pins | input | 8 | Input port pins, asynchronous |
| vec_ack | input | 1 | Core accepted the interrupt vector |
| irq_req | output | 1 | Interrupt request to the core |
| wake | output | 1 | Wake from sleep request |

## Verification
The assertions take a few things for granted about the inputs. tmr_ovf and vec_ack are assumed to be synchronous to clk. The edge-select bit is assumed to stay put while an edge is being seen; the single-edge check steps aside in any cycle where it moves. The stimulus changes the asynchronous pins only at falling clock edges and holds each level for several cycles. It changes the edge select only while ext_pin is steady, and it drives vec_ack and tmr_ovf as single-cycle pulses. Simultaneous events, such as a hardware set meeting a software clear or an acknowledge meeting a write, are produced on purpose by raising both strobes in the same cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_OPT  = 2'd1,
    SEL_PORT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // control register bit positions
  localparam int B_GIE    = 7;
  localparam int B_TMR_EN = 5;
  localparam int B_EXT_EN = 4;
  localparam int B_CHG_EN = 3;
  localparam int B_TMR_F  = 2;
  localparam int B_EXT_F  = 1;
  localparam int B_CHG_F  = 0;
  // option register bit position
  localparam int B_EDGE   = 6;

  // edge qualifier: sel=1 rising, sel=0 falling
  function automatic logic edge_hit(input logic sel, input logic cur, input logic prev);
    return sel ? (cur & ~prev) : (~cur & prev);
  endfunction

  // per-source flag AND enable, {timer, pin, change}
  function automatic logic [2:0] pending(input logic [REG_W-1:0] c);
    return {c[B_TMR_EN] & c[B_TMR_F], c[B_EXT_EN] & c[B_EXT_F], c[B_CHG_EN] & c[B_CHG_F]};
  endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irqc_ext_edge.sv
module irqc_ext_edge
  import irqc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic edge_evt
);
  logic pin_s;
  logic pin_prev;

  irqc_sync #(.W(1), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pin), .q(pin_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pin_prev <= 1'b0;
    else        pin_prev <= pin_s;
  end

  assign edge_evt = edge_hit(rise_sel, pin_s, pin_prev);

  // R3
  ext_edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> (!edge_evt || !$stable(rise_sel)));
endmodule

// File: rtl/irqc_port_chg.sv
module irqc_port_chg
  import irqc_pkg::*;
#(
  parameter int W           = 8,
  parameter int CHG_LO      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic         snap_ld,
  output logic [W-1:0] pins_s,
  output logic         chg_evt
);
  localparam int CW = W - CHG_LO;

  logic [CW-1:0] snap_q;

  irqc_sync #(.W(W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pins), .q(pins_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       snap_q <= '0;
    else if (snap_ld) snap_q <= pins_s[W-1:CHG_LO];
  end

  assign chg_evt = |(snap_q ^ pins_s[W-1:CHG_LO]);

  // R6
  snap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_ld && $stable(pins)) |=> (!chg_evt || !$stable(pins_s)));
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irqc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CHG_LO      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              ext_pin,
  input  logic              tmr_ovf,
  input  logic [REG_W-1:0]  port_pins,
  input  logic              vec_ack,
  output logic              irq_req,
  output logic              wake
);
  logic [REG_W-1:0] ctrl_q, ctrl_d;
  logic             rise_sel_q;
  logic             ext_evt, chg_evt;
  logic [REG_W-1:0] pins_s;
  logic             ctrl_wr, opt_wr, port_rd;
  logic [2:0]       pend;

  assign ctrl_wr = reg_wr && (reg_addr == SEL_CTRL);
  assign opt_wr  = reg_wr && (reg_addr == SEL_OPT);
  assign port_rd = reg_rd && (reg_addr == SEL_PORT);

  irqc_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) ext_i (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise_sel(rise_sel_q), .edge_evt(ext_evt)
  );

  irqc_port_chg #(.W(REG_W), .CHG_LO(CHG_LO), .SYNC_STAGES(SYNC_STAGES)) chg_i (
    .clk(clk), .rst_n(rst_n), .pins(port_pins), .snap_ld(port_rd),
    .pins_s(pins_s), .chg_evt(chg_evt)
  );

  // next state of control register: hardware set beats software clear
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = reg_wdata;
    ctrl_d[B_EDGE] = 1'b0;
    if (vec_ack) ctrl_d[B_GIE] = 1'b0;
    if (tmr_ovf) ctrl_d[B_TMR_F] = 1'b1;
    if (ext_evt) ctrl_d[B_EXT_F] = 1'b1;
    if (chg_evt) ctrl_d[B_CHG_F] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      rise_sel_q <= 1'b1;
    end else begin
      ctrl_q <= ctrl_d;
      if (opt_wr) rise_sel_q <= reg_wdata[B_EDGE];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      SEL_CTRL: reg_rdata = ctrl_q;
      SEL_OPT:  reg_rdata[B_EDGE] = rise_sel_q;
      SEL_PORT: reg_rdata = pins_s;
      default:  reg_rdata = '0;
    endcase
  end

  assign pend    = pending(ctrl_q);
  assign wake    = |pend;
  assign irq_req = wake & ctrl_q[B_GIE];

  // R3
  ext_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_evt |=> ctrl_q[B_EXT_F]);
  // R5
  tmr_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> ctrl_q[B_TMR_F]);
  // R6
  chg_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_evt |=> ctrl_q[B_CHG_F]);
  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && ctrl_q[B_TMR_F]) |=> ctrl_q[B_TMR_F]);
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !reg_wdata[B_EXT_F] && ext_evt) |=> ctrl_q[B_EXT_F]);
  // R11
  ack_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ack |=> !irq_req);
  // R10
  irq_needs_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> wake);
  // R2
  bit6_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !ctrl_q[B_EDGE]);
endmodule

// File: tb/irq_flag_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_flag_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ext_pin = 1'b0;
  logic       tmr_ovf = 1'b0;
  logic [7:0] port_pins = '0;
  logic       vec_ack = 1'b0;
  logic       irq_req, wake;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_flag_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
    .port_pins(port_pins), .vec_ack(vec_ack), .irq_req(irq_req), .wake(wake)
  );

  // {addr, write data, expected read}
  localparam int NV = 9;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'h38, 8'h38},
    {2'd0, 8'hFF, 8'hBF},
    {2'd0, 8'h00, 8'h00},
    {2'd1, 8'h00, 8'h00},
    {2'd1, 8'hFF, 8'h40},
    {2'd1, 8'hBF, 8'h00},
    {2'd1, 8'h40, 8'h40},
    {2'd3, 8'hAA, 8'h00},
    {2'd0, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    rd(2'd0, d); check("R1 ctrl", d, 8'h00);
    rd(2'd1, d); check("R1 opt", d, 8'h40);
    check("R1 irq/wake", {6'd0, irq_req, wake}, 8'h00);

    // R2 register map table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][17:16], VEC[i][15:8]);
      rd(VEC[i][17:16], d);
      check("R2 map", d, VEC[i][7:0]);
    end

    // R3 rising edge
    ext_pin = 1'b1; cyc(4);
    rd(2'd0, d); check("R3 rise sets flag", d, 8'h02);
    wr(2'd0, 8'h00);
    // R4 falling ignored while rising selected
    ext_pin = 1'b0; cyc(4);
    rd(2'd0, d); check("R4 fall ignored", d, 8'h00);
    wr(2'd1, 8'h00);
    ext_pin = 1'b1; cyc(4);
    rd(2'd0, d); check("R4 rise ignored", d, 8'h00);
    ext_pin = 1'b0; cyc(4);
    rd(2'd0, d); check("R4 fall sets flag", d, 8'h02);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h40);

    // R5 timer pulse
    tmr_ovf = 1'b1; cyc(1); tmr_ovf = 1'b0;
    rd(2'd0, d); check("R5 timer flag", d, 8'h04);
    // R7 sticky without writes
    cyc(5);
    rd(2'd0, d); check("R7 sticky", d, 8'h04);
    wr(2'd0, 8'h00);
    rd(2'd0, d); check("R7 sw clear", d, 8'h00);
    wr(2'd0, 8'h02);
    rd(2'd0, d); check("R7 sw set", d, 8'h02);
    wr(2'd0, 8'h00);

    // R6 port change
    port_pins = 8'h10; cyc(4);
    rd(2'd0, d); check("R6 upper change", d, 8'h01);
    rd(2'd2, d); check("R6 port read", d, 8'h10);
    wr(2'd0, 8'h00); cyc(2);
    rd(2'd0, d); check("R6 snapshot rearmed", d, 8'h00);
    port_pins = 8'h12; cyc(4);
    rd(2'd0, d); check("R6 lower ignored", d, 8'h00);

    // R8 set beats clear
    reg_addr = 2'd0; reg_wdata = 8'h00; reg_wr = 1'b1; tmr_ovf = 1'b1;
    cyc(1);
    reg_wr = 1'b0; tmr_ovf = 1'b0;
    rd(2'd0, d); check("R8 set wins", d, 8'h04);
    wr(2'd0, 8'h00);

    // R9 / R10 / R11
    wr(2'd0, 8'h24);
    check("R9 wake without gie", {6'd0, irq_req, wake}, 8'h01);
    wr(2'd0, 8'hA4);
    check("R10 irq with gie", {6'd0, irq_req, wake}, 8'h03);
    wr(2'd0, 8'h84);
    check("R10 no enable", {6'd0, irq_req, wake}, 8'h00);
    wr(2'd0, 8'hA4);
    vec_ack = 1'b1; cyc(1); vec_ack = 1'b0;
    check("R11 ack drops irq", {6'd0, irq_req, wake}, 8'h01);
    rd(2'd0, d); check("R11 gie cleared", d, 8'h24);
    reg_addr = 2'd0; reg_wdata = 8'hA4; reg_wr = 1'b1; vec_ack = 1'b1;
    cyc(1);
    reg_wr = 1'b0; vec_ack = 1'b0;
    rd(2'd0, d); check("R11 ack beats write", d, 8'h24);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule